// File: doc/BRIEF.md
# Sync Word Detector with AFC Hold Window

This block watches a stream of recovered receive bits, one per accepted beat, and keeps the most recent 24 of them in a sliding window. After each accepted bit the window is compared with a programmed 24-bit sync pattern. Up to a programmed number of bit positions (0 to 3) may differ. When the window matches, the block raises a one-cycle detect pulse.

When the lock-on-sync mode is enabled, a detect also starts a hold window on the AFC lock output. This output tells the frequency-correction loop to freeze its estimate. The window lasts a programmed number of bytes, counted in accepted bits from the end of the sync word. Every detect starts or restarts the window, whether it comes from a real sync word or from noise that happens to match.

The bit input follows valid/ready rules. The block never applies back-pressure, so `bit_ready` stays high and each cycle with `bit_valid` high delivers exactly one bit. The configuration pins are plain levels and are sampled in the cycle of each accepted bit.

Top module: `sync_hunt_top`

## Requirements
- R1: `bit_ready` is always 1. Each cycle with `bit_valid` high shifts `bit_data` into the window as the newest bit. After 24 accepted bits, the first bit received sits at window bit 23, so `sync_pattern[23]` is compared with the earliest bit of the word.
- R2: No detect is reported until at least 24 bits have been accepted since reset, even if the partly filled window already equals the pattern.
- R3: A match is declared when the number of positions where the window differs from `sync_pattern` is at most `err_allow` (0 to 3). The match raises `detect_pulse` in the cycle after the accepted bit that completed it. If the window differs in more positions than `err_allow`, no detect is raised.
- R4: `detect_pulse` is high for exactly one cycle per matching accepted bit, and it is low in any cycle that does not follow an accepted bit.
- R5: With `lock_on_sync`=1 and `pkt_bytes`=N>0, a detect raises `afc_hold` in the same cycle as `detect_pulse`. `afc_hold` stays high through the next 8*N-1 accepted bits and falls in the cycle after the 8*N-th accepted bit.
- R6: With `lock_on_sync`=0, a detect pulses `detect_pulse` but leaves `afc_hold` low.
- R7: With `lock_on_sync`=1 and `pkt_bytes`=0, a detect produces no hold: `afc_hold` is low after it.
- R8: A detect that occurs while the hold window is running reloads it. The window then ends 8*N accepted bits after the new detect.
- R9: An active-low reset clears the window, the fill count, `detect_pulse` and `afc_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A bit is offered this cycle |
| bit_data | input | 1 | Offered receive bit |
| bit_ready | output | 1 | Always 1; the block accepts every offered bit |
| sync_pattern | input | 24 | Programmed sync word; bit 23 is compared with the earliest bit |
| err_allow | input | 2 | Number of mismatching bit positions tolerated |
| pkt_bytes | input | 8 | Hold window length in bytes |
| lock_on_sync | input | 1 | 1: a detect starts the AFC hold window |
| detect_pulse | output | 1 | One-cycle pulse on each match |
| afc_hold | output | 1 | AFC lock level |

## Verification
The hardest situation to reach is a second detect that arrives while a hold window is already running. A real sync word takes 24 bits, so the hold must be longer than that for a re-detect to land inside it. The bench therefore programs a 4-byte hold and sends two sync words back to back. It then counts 8*N bits from the second detect, which separates a reload from a window that merely runs on from the first detect. The bench also injects chosen error masks of known weight against each tolerance setting. This exercises the boundary between accepted and rejected near-matches.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  localparam int SYNC_BITS_DEF = 24;
  localparam int TOL_W_DEF     = 2;
  localparam int LEN_W_DEF     = 8;
  localparam int BYTE_BITS     = 8;

  function automatic int cnt_w(input int max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sync_window.sv
module sync_window #(
  parameter int WIN = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           bit_in,
  output logic [WIN-1:0] win_next,
  output logic           full_next
);
  localparam int FILL_W = sync_hunt_pkg::cnt_w(WIN);

  logic [WIN-1:0]    shreg;
  logic [FILL_W-1:0] fill;

  assign win_next  = {shreg[WIN-2:0], bit_in};
  assign full_next = (fill >= FILL_W'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      fill  <= '0;
    end else if (take) begin
      shreg <= win_next;
      if (fill != FILL_W'(WIN)) fill <= fill + FILL_W'(1);
    end
  end
endmodule

// File: rtl/sync_mismatch.sv
module sync_mismatch #(
  parameter int WIN = 24,
  parameter int MISS_W = 5
) (
  input  logic [WIN-1:0]    seen,
  input  logic [WIN-1:0]    want,
  output logic [MISS_W-1:0] count
);
  logic [WIN-1:0] diff;
  assign diff = seen ^ want;

  always_comb begin
    count = '0;
    for (int i = 0; i < WIN; i++) count = count + MISS_W'(diff[i]);
  end
endmodule

// File: rtl/sync_hold_timer.sv
module sync_hold_timer #(
  parameter int LEN_W = 8,
  parameter int BYTE_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             hold
);
  localparam int PH_W = $clog2(BYTE_BITS);

  logic [LEN_W-1:0] bytes_left;
  logic [PH_W-1:0]  phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_left <= '0;
      phase      <= '0;
      hold       <= 1'b0;
    end else if (load) begin
      bytes_left <= len;
      phase      <= '0;
      hold       <= (len != '0);
    end else if (take && hold) begin
      if (phase == PH_W'(BYTE_BITS - 1)) begin
        phase      <= '0;
        bytes_left <= bytes_left - LEN_W'(1);
        if (bytes_left == LEN_W'(1)) hold <= 1'b0;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/sync_hunt_top.sv
module sync_hunt_top #(
  parameter int WIN   = sync_hunt_pkg::SYNC_BITS_DEF,
  parameter int TOL_W = sync_hunt_pkg::TOL_W_DEF,
  parameter int LEN_W = sync_hunt_pkg::LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  input  logic [WIN-1:0]   sync_pattern,
  input  logic [TOL_W-1:0] err_allow,
  input  logic [LEN_W-1:0] pkt_bytes,
  input  logic             lock_on_sync,
  output logic             detect_pulse,
  output logic             afc_hold
);
  localparam int MISS_W = sync_hunt_pkg::cnt_w(WIN);

  logic              take;
  logic [WIN-1:0]    win_next;
  logic              full_next;
  logic [MISS_W-1:0] miss;
  logic              hit;

  assign bit_ready = 1'b1;
  assign take      = bit_valid & bit_ready;

  sync_window #(.WIN(WIN)) u_window (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(bit_data),
    .win_next(win_next), .full_next(full_next)
  );

  sync_mismatch #(.WIN(WIN), .MISS_W(MISS_W)) u_mismatch (
    .seen(win_next), .want(sync_pattern), .count(miss)
  );

  assign hit = take & full_next & (miss <= MISS_W'(err_allow));

  always_ff @(posedge clk) begin
    if (!rst_n) detect_pulse <= 1'b0;
    else        detect_pulse <= hit;
  end

  sync_hold_timer #(.LEN_W(LEN_W), .BYTE_BITS(sync_hunt_pkg::BYTE_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take),
    .load(hit & lock_on_sync), .len(pkt_bytes), .hold(afc_hold)
  );
endmodule

// File: rtl/sync_hunt_checker.sv
module sync_hunt_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             bit_ready,
  input logic [LEN_W-1:0] pkt_bytes,
  input logic             lock_on_sync,
  input logic             detect_pulse,
  input logic             afc_hold
);
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) bit_ready); // R1
  AST_DETECT_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    detect_pulse |-> $past(bit_valid)); // R4
  AST_HOLD_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(afc_hold) |-> (detect_pulse && $past(lock_on_sync))); // R5
  AST_HOLD_FALL_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(afc_hold) |-> $past(bit_valid)); // R5
  AST_ZERO_LEN_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_pulse && $past(lock_on_sync) && ($past(pkt_bytes) == '0)) |-> !afc_hold); // R7
endmodule

bind sync_hunt_top sync_hunt_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
  .pkt_bytes(pkt_bytes), .lock_on_sync(lock_on_sync),
  .detect_pulse(detect_pulse), .afc_hold(afc_hold)
);

// File: tb/sync_hunt_top_bench.sv
module sync_hunt_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        bit_ready;
  logic [23:0] sync_pattern = 24'hD4C95A;
  logic [1:0]  err_allow = 2'd0;
  logic [7:0]  pkt_bytes = 8'd0;
  logic        lock_on_sync = 1'b0;
  logic        detect_pulse;
  logic        afc_hold;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sync_hunt_top u_sync_hunt_top (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .sync_pattern(sync_pattern), .err_allow(err_allow),
    .pkt_bytes(pkt_bytes), .lock_on_sync(lock_on_sync),
    .detect_pulse(detect_pulse), .afc_hold(afc_hold)
  );

  // {pattern, tolerance, injected error mask}
  localparam logic [49:0] VEC [8] = '{
    {24'hD4C95A, 2'd0, 24'h000000},
    {24'hD4C95A, 2'd0, 24'h000001},
    {24'hD4C95A, 2'd1, 24'h800000},
    {24'hD4C95A, 2'd1, 24'h000101},
    {24'hD4C95A, 2'd2, 24'h000101},
    {24'hD4C95A, 2'd3, 24'h010101},
    {24'hD4C95A, 2'd3, 24'h0F0000},
    {24'h3A5F0C, 2'd2, 24'h400002}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1; bit_data = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] w, input int count);
    for (int i = 23; i > 23 - count; i--) send_bit(w[i]);
  endtask

  task automatic idle_then_check_hold(input int nbits, input string req);
    for (int i = 0; i < nbits - 1; i++) send_bit(i[0]);
    check(req, afc_hold, 1'b1);
    send_bit(1'b0);
    check(req, afc_hold, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R9 reset detect", detect_pulse, 1'b0);
    check("R9 reset hold", afc_hold, 1'b0);
    check("R1 ready", bit_ready, 1'b1);

    // R3 table walk: error weight against tolerance
    for (int v = 0; v < 8; v++) begin
      logic [23:0] pat, msk;
      logic [1:0]  tol;
      {pat, tol, msk} = VEC[v];
      do_reset();
      sync_pattern = pat; err_allow = tol; lock_on_sync = 1'b0;
      send_word(pat ^ msk, 23);
      check("R2 no early detect", detect_pulse, 1'b0);
      send_bit(pat[0] ^ msk[0]);
      check("R3 match vs tolerance", detect_pulse, ($countones(msk) <= tol));
    end

    // R2: all-zero pattern equals cleared window, yet needs 24 bits
    do_reset();
    sync_pattern = 24'h0; err_allow = 2'd0;
    send_word(24'h0, 23);
    check("R2 fill gate", detect_pulse, 1'b0);
    send_bit(1'b0);
    check("R2 full window", detect_pulse, 1'b1);
    @(negedge clk);
    check("R4 pulse one cycle", detect_pulse, 1'b0);

    // R6 mode off
    do_reset();
    sync_pattern = 24'hD4C95A; err_allow = 2'd0; pkt_bytes = 8'd3; lock_on_sync = 1'b0;
    send_word(24'hD4C95A, 24);
    check("R6 detect", detect_pulse, 1'b1);
    check("R6 no hold", afc_hold, 1'b0);

    // R5 hold length 3 bytes
    do_reset();
    lock_on_sync = 1'b1; pkt_bytes = 8'd3;
    send_word(24'hD4C95A, 24);
    check("R5 hold rises", afc_hold, 1'b1);
    idle_then_check_hold(24, "R5 hold length");

    // R7 zero length
    do_reset();
    pkt_bytes = 8'd0;
    send_word(24'hD4C95A, 24);
    check("R7 detect", detect_pulse, 1'b1);
    check("R7 no hold", afc_hold, 1'b0);

    // R8 reload
    do_reset();
    pkt_bytes = 8'd4;
    send_word(24'hD4C95A, 24);
    check("R8 first hold", afc_hold, 1'b1);
    send_word(24'hD4C95A, 24);
    check("R8 second detect", detect_pulse, 1'b1);
    idle_then_check_hold(32, "R8 reload");

    // R9 reset during hold
    pkt_bytes = 8'd5;
    send_word(24'hD4C95A, 24);
    check("R9 hold before reset", afc_hold, 1'b1);
    do_reset();
    @(negedge clk);
    check("R9 hold cleared", afc_hold, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule